// File: doc/BRIEF.md
# Multithread Fetch Thread Selector

This block decides, every cycle, which hardware thread the front pipeline stage fetches from. Each thread reports a two-bit state and an active flag. A policy input picks one of two selection modes. In the fixed mode, a designated thread is always granted. In the rotating mode, the block walks an ordered list of thread IDs and grants the first thread that can fetch.

The grant is combinational from the current inputs and the stored list. The list is a least-recently-granted order. When a rotating-mode grant is taken, which the consumer signals with a select strobe, the winner leaves its slot and goes to the tail. All other entries shift up one place and keep their order.

When only one thread is active, the block skips both the policy and the list. With no active thread, it grants nothing.

Top module: `fts_thread_sel`

## Requirements
- R1: A thread can be granted by the list scan only when its state field (bits [2t+1:2t] of `thr_state`) is 0 (running) or 1 (idle). Codes 2 (blocked) and 3 (squashing) exclude it.
- R2: With two or more active threads and policy 1 (rotate), the grant is the first thread, scanning the list from head to tail, that R1 allows. `grant_valid` is then high.
- R3: When `sel_strobe` is high at a clock edge and R2 produced a valid grant, the granted ID moves to the list tail. The other entries keep their relative order.
- R4: When `sel_strobe` is low, the list is not changed.
- R5: If no thread in the list is allowed by R1 under R2, `grant_valid` is low and the list is unchanged.
- R6: With two or more active threads and policy 0 (fixed), the grant is `fixed_tid`, valid, whatever the states are. The list is not changed.
- R7: With exactly one bit of `thr_active` set, that thread is granted if its state is 0 or 1. Otherwise `grant_valid` is low. The list is never changed in this case.
- R8: With `thr_active` all zero, `grant_valid` is low.
- R9: With two or more active threads and policy 2 or 3, `grant_valid` is low and the list is unchanged.
- R10: Synchronous reset loads the list in ascending order 0..N-1 from head to tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_state | input | 2*N_THREADS | Per-thread state, two bits each, thread t at [2t+1:2t] |
| thr_active | input | N_THREADS | Per-thread active flag |
| policy | input | 2 | 0 fixed, 1 rotate, 2/3 unsupported |
| fixed_tid | input | TID_W | Thread granted under the fixed policy |
| sel_strobe | input | 1 | Commit the rotating grant into the list |
| grant_tid | output | TID_W | Granted thread ID (0 when invalid) |
| grant_valid | output | 1 | Grant is valid |

## Verification
The list contents are hidden. The hardest case is proving that a rotation happened, or did not happen, after a given step. The only way to see the list is through later rotating-mode grants.

The bench keeps its own model of the list. It sweeps all 256 combinations of four-thread state codes under the rotate policy, with the strobe toggling in a fixed pattern. The model has to match every grant, so any wrong or missing rotation shows up in later steps.

Fixed-policy, single-active, zero-active and unsupported-policy steps are interleaved with the sweep while the strobe is high. A wrongly rotated list therefore shows up in the rotating grants that follow.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int STATE_W = 2;

  localparam logic [STATE_W-1:0] ST_RUNNING   = 2'd0;
  localparam logic [STATE_W-1:0] ST_IDLE      = 2'd1;
  localparam logic [STATE_W-1:0] ST_BLOCKED   = 2'd2;
  localparam logic [STATE_W-1:0] ST_SQUASHING = 2'd3;

  localparam logic [1:0] POL_FIXED  = 2'd0;
  localparam logic [1:0] POL_ROTATE = 2'd1;

  function automatic logic can_fetch(input logic [STATE_W-1:0] st);
    return (st == ST_RUNNING) || (st == ST_IDLE);
  endfunction
endpackage

// File: rtl/fts_elig.sv
module fts_elig
  import fts_pkg::*;
#(
  parameter int N_THREADS = 4
) (
  input  logic [N_THREADS*STATE_W-1:0] thr_state,
  output logic [N_THREADS-1:0]         elig
);
  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    assign elig[t] = can_fetch(thr_state[t*STATE_W +: STATE_W]);
  end
endmodule

// File: rtl/fts_prio_list.sv
module fts_prio_list #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rotate_en,
  input  logic [TID_W-1:0]           rotate_pos,
  output logic [N_THREADS*TID_W-1:0] order_flat
);
  logic [TID_W-1:0] order_q [N_THREADS];
  logic [TID_W-1:0] order_d [N_THREADS];

  for (genvar i = 0; i < N_THREADS; i++) begin : g_slot
    assign order_flat[i*TID_W +: TID_W] = order_q[i];

    if (i == N_THREADS - 1) begin : g_tail
      assign order_d[i] = order_q[rotate_pos];
    end else begin : g_body
      assign order_d[i] = (TID_W'(i) < rotate_pos) ? order_q[i] : order_q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)            order_q[i] <= TID_W'(i);
      else if (rotate_en) order_q[i] <= order_d[i];
    end
  end
endmodule

// File: rtl/fts_scan.sv
module fts_scan #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input  logic [N_THREADS*TID_W-1:0] order_flat,
  input  logic [N_THREADS-1:0]       elig,
  output logic                       hit,
  output logic [TID_W-1:0]           hit_pos,
  output logic [TID_W-1:0]           hit_tid
);
  logic [N_THREADS-1:0] slot_ok;

  for (genvar i = 0; i < N_THREADS; i++) begin : g_slot
    assign slot_ok[i] = elig[order_flat[i*TID_W +: TID_W]];
  end

  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    hit_tid = '0;
    for (int i = N_THREADS - 1; i >= 0; i--) begin
      if (slot_ok[i]) begin
        hit     = 1'b1;
        hit_pos = TID_W'(i);
        hit_tid = order_flat[i*TID_W +: TID_W];
      end
    end
  end
endmodule

// File: rtl/fts_thread_sel.sv
module fts_thread_sel
  import fts_pkg::*;
#(
  parameter int N_THREADS = 4,
  parameter int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_THREADS*STATE_W-1:0] thr_state,
  input  logic [N_THREADS-1:0]         thr_active,
  input  logic [1:0]                   policy,
  input  logic [TID_W-1:0]             fixed_tid,
  input  logic                         sel_strobe,
  output logic [TID_W-1:0]             grant_tid,
  output logic                         grant_valid
);
  localparam int CNT_W = TID_W + 1;

  logic [N_THREADS-1:0]       elig;
  logic [N_THREADS*TID_W-1:0] order_flat;
  logic                       scan_hit;
  logic [TID_W-1:0]           scan_pos;
  logic [TID_W-1:0]           scan_tid;
  logic [CNT_W-1:0]           n_active;
  logic [TID_W-1:0]           lone_tid;
  logic                       multi;
  logic                       rotate_path;

  fts_elig #(.N_THREADS(N_THREADS)) u_elig (
    .thr_state (thr_state),
    .elig      (elig)
  );

  fts_prio_list #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_list (
    .clk        (clk),
    .rst        (rst),
    .rotate_en  (rotate_path && scan_hit && sel_strobe),
    .rotate_pos (scan_pos),
    .order_flat (order_flat)
  );

  fts_scan #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_scan (
    .order_flat (order_flat),
    .elig       (elig),
    .hit        (scan_hit),
    .hit_pos    (scan_pos),
    .hit_tid    (scan_tid)
  );

  always_comb begin
    n_active = '0;
    lone_tid = '0;
    for (int t = 0; t < N_THREADS; t++) begin
      n_active = n_active + CNT_W'(thr_active[t]);
      if (thr_active[t]) lone_tid = TID_W'(t);
    end
  end

  assign multi       = n_active > CNT_W'(1);
  assign rotate_path = multi && (policy == POL_ROTATE);

  always_comb begin
    grant_tid   = '0;
    grant_valid = 1'b0;
    if (multi) begin
      if (policy == POL_FIXED) begin
        grant_tid   = fixed_tid;
        grant_valid = 1'b1;
      end else if (policy == POL_ROTATE && scan_hit) begin
        grant_tid   = scan_tid;
        grant_valid = 1'b1;
      end
    end else if (n_active == CNT_W'(1) && elig[lone_tid]) begin
      grant_tid   = lone_tid;
      grant_valid = 1'b1;
    end
  end
endmodule

// File: rtl/fts_checker.sv
module fts_checker
  import fts_pkg::*;
#(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic [N_THREADS*STATE_W-1:0] thr_state,
  input logic [N_THREADS-1:0]         thr_active,
  input logic [1:0]                   policy,
  input logic [TID_W-1:0]             fixed_tid,
  input logic                         sel_strobe,
  input logic [TID_W-1:0]             grant_tid,
  input logic                         grant_valid
);
  logic grant_ok;
  logic all_ok;
  logic multi;
  logic rr_all;

  always_comb begin
    grant_ok = 1'b0;
    all_ok   = 1'b1;
    for (int t = 0; t < N_THREADS; t++) begin
      if (TID_W'(t) == grant_tid) grant_ok = can_fetch(thr_state[t*STATE_W +: STATE_W]);
      if (!can_fetch(thr_state[t*STATE_W +: STATE_W])) all_ok = 1'b0;
    end
  end

  assign multi  = $countones(thr_active) > 1;
  assign rr_all = multi && policy == POL_ROTATE && all_ok;

  AST_NONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    thr_active == '0 |-> !grant_valid); // R8

  AST_FIXED_GRANT: assert property (@(posedge clk) disable iff (rst)
    (multi && policy == POL_FIXED) |-> (grant_valid && grant_tid == fixed_tid)); // R6

  AST_BAD_POLICY: assert property (@(posedge clk) disable iff (rst)
    (multi && policy[1]) |-> !grant_valid); // R9

  AST_LONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    ($countones(thr_active) == 1 && grant_valid) |-> (thr_active[grant_tid] && grant_ok)); // R7

  AST_ROTATE_ELIG: assert property (@(posedge clk) disable iff (rst)
    (multi && policy == POL_ROTATE && grant_valid) |-> grant_ok); // R1

  AST_ROTATE_MOVES: assert property (@(posedge clk) disable iff (rst)
    (rr_all && sel_strobe) |=> (rr_all -> grant_tid != $past(grant_tid))); // R3
endmodule

bind fts_thread_sel fts_checker #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_fts_checker (
  .clk         (clk),
  .rst         (rst),
  .thr_state   (thr_state),
  .thr_active  (thr_active),
  .policy      (policy),
  .fixed_tid   (fixed_tid),
  .sel_strobe  (sel_strobe),
  .grant_tid   (grant_tid),
  .grant_valid (grant_valid)
);

// File: tb/fts_thread_sel_bench.sv
module fts_thread_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [2*N-1:0] thr_state;
  logic [N-1:0]  thr_active;
  logic [1:0]    policy;
  logic [TW-1:0] fixed_tid;
  logic          sel_strobe;
  logic [TW-1:0] grant_tid;
  logic          grant_valid;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int mlist [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  fts_thread_sel #(.N_THREADS(N)) u_fts_thread_sel (
    .clk(clk), .rst(rst), .thr_state(thr_state), .thr_active(thr_active),
    .policy(policy), .fixed_tid(fixed_tid), .sel_strobe(sel_strobe),
    .grant_tid(grant_tid), .grant_valid(grant_valid)
  );

  function automatic bit ok_state(input logic [2*N-1:0] st, input int t);
    return st[2*t +: 2] < 2;
  endfunction

  task automatic check(input string req, input bit ev, input int et);
    n_checks++;
    if (grant_valid !== ev || (ev && grant_tid !== TW'(et))) begin
      n_errors++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, grant_valid, grant_tid, ev, et);
    end
  endtask

  // Drive at negedge, check combinational grant, model commit at next posedge
  task automatic step(input string req, input logic [2*N-1:0] st, input logic [N-1:0] act,
                      input logic [1:0] pol, input int ft, input bit stb);
    bit ev; int et; int pos; int cnt;
    @(negedge clk);
    thr_state = st; thr_active = act; policy = pol; fixed_tid = TW'(ft); sel_strobe = stb;
    ev = 0; et = 0; pos = -1; cnt = $countones(act);
    if (cnt > 1) begin
      if (pol == 0) begin ev = 1; et = ft; end
      else if (pol == 1) begin
        for (int i = 0; i < N; i++)
          if (pos < 0 && ok_state(st, mlist[i])) begin pos = i; ev = 1; et = mlist[i]; end
      end
    end else if (cnt == 1) begin
      for (int t = 0; t < N; t++)
        if (act[t] && ok_state(st, t)) begin ev = 1; et = t; end
    end
    #1;
    check(req, ev, et);
    if (cnt > 1 && pol == 1 && pos >= 0 && stb) begin
      int w;
      w = mlist[pos];
      for (int i = pos; i < N-1; i++) mlist[i] = mlist[i+1];
      mlist[N-1] = w;
    end
  endtask

  initial begin
    rst = 1; thr_state = '0; thr_active = '0; policy = 0; fixed_tid = 0; sel_strobe = 0;
    for (int i = 0; i < N; i++) mlist[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R10: ascending order after reset, R3 rotation visible
    for (int k = 0; k < N; k++) step("R10", '0, 4'hF, 1, 0, 1);
    // R4: no strobe keeps grant and list
    step("R4", '0, 4'hF, 1, 0, 0);
    step("R4", '0, 4'hF, 1, 0, 0);
    // R8: none active
    step("R8", '0, 4'h0, 1, 0, 1);
    // R5: nothing eligible
    step("R5", 8'hFF, 4'hF, 1, 0, 1);
    step("R5", 8'hAA, 4'hF, 1, 0, 1);

    // R1 R2 R3 R4: sweep all state codes under rotate policy
    for (int s = 0; s < 256; s++) begin
      step("R2", 8'(s), 4'hF, 1, 0, (s % 3) != 0);
      if (s % 32 == 5) begin
        // R6 fixed: any state, strobe high, no rotation
        step("R6", 8'(s), 4'h6, 0, s % N, 1);
        // R9 unsupported policies
        step("R9", 8'(s), 4'hB, 2, 0, 1);
        step("R9", '0, 4'hF, 3, 1, 1);
        // R7 lone active thread in every state
        for (int t = 0; t < N; t++)
          for (int c = 0; c < 4; c++)
            step("R7", 8'(c << (2*t)), 4'(1 << t), 1, 0, 1);
        step("R8", 8'(s), 4'h0, 0, 2, 1);
        step("R3", '0, 4'hF, 1, 0, 1);
      end
    end

    // R1: only blocked/squashing codes excluded, full single-eligible patterns
    for (int t = 0; t < N; t++) begin
      logic [2*N-1:0] st;
      st = 8'hFF;
      st[2*t +: 2] = 2'(t % 2);
      step("R1", st, 4'hF, 1, 0, 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got running, expected done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule